// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM that can carry a transfer on every clock, with reads and writes mixed in any order and no idle cycle when the direction changes. The address, direction, cycle-start, clock-enable, three chip-select pins and per-byte write enables are all captured on the rising clock edge. Read data is flow-through: the word appears in the same cycle that follows the edge that registered its address, with no extra output stage. Write data arrives one edge after its address.

A one-deep write buffer holds the last accepted write until the next enabled edge commits it to the array. Reads that hit the buffered address see the buffered bytes merged with the array, so the memory always looks coherent. A 2-bit burst counter lets a single loaded address produce four consecutive accesses in linear or interleaved order. An active-high clock-enable stall freezes the whole pipeline, including a pending write. The word holds two 9-bit bytes by default and the depth is a parameter: the address width is 10 by default and can be raised to 17 for a 128K-word part.

Top module: `zbt_flowthru_sram`

## Requirements
- R1: Reads and writes may be issued on consecutive enabled edges in any order, and each keeps its own result with no dead cycle between them.
- R2: A load edge selects the device only when sel1_n=0, sel2=1 and sel3_n=0. Any other combination makes that cycle a deselect, and rdata_vld is 0 after that edge.
- R3: While clk_en_n=1, an edge changes nothing. The burst position, the direction, the pending write and the array all hold, and rdata keeps showing the same word.
- R4: load_n=0 starts a new cycle with the address on addr and the direction from rd_wr_n (1=read, 0=write). load_n=1 advances the burst and keeps the last direction and selection, so an advance after a deselect stays deselected.
- R5: The burst count starts at 0 on a load and steps by 1 on each advance, wrapping modulo 4. It replaces only addr[1:0]. With burst_ilv=0 (linear) that field becomes start+count mod 4. With burst_ilv=1 (interleaved) it becomes start XOR count.
- R6: byte_we_n is active low. Bit 0 gates data bits 8:0 and bit 1 gates data bits 17:9. Bytes that are not enabled keep their old value.
- R7: For a selected read registered at an edge, rdata_vld is 1 and rdata carries the addressed word during the cycle that follows that edge.
- R8: out_en_n=1 forces rdata_vld to 0 and rdata to 0 at once, without waiting for a clock edge.
- R9: The data for a write is taken from wdata on the next enabled edge after the edge that registered the write's address and byte enables.
- R10: A read of an address whose write is still in the buffer returns the buffered bytes merged with the array bytes that were not enabled.
- R11: A deselect cycle does not cancel a write registered on the edge before it. The data on the deselect edge is still written.
- R12: After reset no cycle is active, and rdata_vld stays 0 until a selected read is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls |
| load_n | input | 1 | Low: load a new cycle; high: advance the burst |
| rd_wr_n | input | 1 | Direction on a load: 1 read, 0 write |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| sel3_n | input | 1 | Active-low chip select |
| byte_we_n | input | NUM_BYTES | Active-low per-byte write enables |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | NUM_BYTES*BYTE_W | Write data (one edge after the address) |
| rdata | output | NUM_BYTES*BYTE_W | Flow-through read data |
| rdata_vld | output | 1 | Read data valid |

## Verification
Single reads and writes that alternate on back-to-back edges show whether the late-write data lines up with the right address and whether direction changes cost a cycle. Reading an address on the edge right after its write, with full and partial byte enables, tells a coherent buffer merge apart from a stale array read. Four-beat bursts from unaligned start addresses in both orders separate the linear and interleaved wrap. Stalls inside read and write bursts, a deselect right after a write, each of the three select pins on its own, and toggling the output enable during a stall check the freeze, select decoding, no-cancel and asynchronous gating rules.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   localparam int BURST_W = 2;

   // Low address bits of a burst beat: XOR with the count in interleaved
   // order, modulo-4 sum in linear order.
   function automatic logic [BURST_W-1:0] beat_lsb(
      input logic [BURST_W-1:0] start,
      input logic [BURST_W-1:0] count,
      input logic               ilv
   );
      return ilv ? (start ^ count) : (start + count);
   endfunction

endpackage

// File: rtl/zbt_seq_ctrl.sv
module zbt_seq_ctrl #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              load_n,
   input  logic              rd_wr_n,
   input  logic              sel1_n,
   input  logic              sel2,
   input  logic              sel3_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              burst_ilv,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              rd_cyc,
   output logic              wr_cyc
);
   import zbt_pkg::*;

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic               act_q;
   logic               wr_q;
   logic               sel_ok;

   assign sel_ok = ~sel1_n & sel2 & ~sel3_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
         wr_q   <= 1'b0;
      end else if (!clk_en_n) begin
         if (!load_n) begin
            base_q <= addr;
            cnt_q  <= '0;
            act_q  <= sel_ok;
            wr_q   <= ~rd_wr_n;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign cur_addr = {base_q[ADDR_W-1:BURST_W], beat_lsb(base_q[BURST_W-1:0], cnt_q, burst_ilv)};
   assign rd_cyc   = act_q & ~wr_q;
   assign wr_cyc   = act_q & wr_q;

   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(base_q) && $stable(cnt_q) && $stable(act_q) && $stable(wr_q)); // R3
   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n) |=> (cnt_q == '0)); // R4
   AST_ADV_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && load_n) |=> $stable(wr_q) && $stable(act_q)); // R4
   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && load_n) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1))); // R5
   AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n && (sel1_n || !sel2 || sel3_n)) |=> !act_q); // R2

endmodule

// File: rtl/zbt_wr_buffer.sv
module zbt_wr_buffer #(
   parameter int ADDR_W    = 10,
   parameter int BYTE_W    = 9,
   parameter int NUM_BYTES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clk_en_n,
   input  logic                        wr_cyc,
   input  logic [ADDR_W-1:0]           cur_addr,
   input  logic [NUM_BYTES-1:0]        byte_we_n,
   input  logic [NUM_BYTES*BYTE_W-1:0] wdata,
   output logic                        buf_v,
   output logic [ADDR_W-1:0]           buf_a,
   output logic [NUM_BYTES-1:0]        buf_be,
   output logic [NUM_BYTES*BYTE_W-1:0] buf_d
);
   logic [NUM_BYTES-1:0] be_q;

   // be_q belongs to the cycle registered at this edge; buffer captures the
   // previous cycle's address/enables together with the data that follows.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         be_q   <= '0;
         buf_v  <= 1'b0;
         buf_a  <= '0;
         buf_be <= '0;
         buf_d  <= '0;
      end else if (!clk_en_n) begin
         be_q   <= ~byte_we_n;
         buf_v  <= wr_cyc;
         buf_a  <= cur_addr;
         buf_be <= be_q;
         buf_d  <= wdata;
      end
   end

   AST_DATA_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en_n |=> (buf_v == $past(wr_cyc))); // R9
   AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(buf_v) && $stable(buf_d) && $stable(buf_a)); // R3

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
   parameter int ADDR_W    = 10,
   parameter int BYTE_W    = 9,
   parameter int NUM_BYTES = 2
) (
   input  logic                        clk,
   input  logic                        clk_en_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [NUM_BYTES-1:0]        wr_be,
   input  logic [NUM_BYTES*BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [NUM_BYTES*BYTE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (!clk_en_n && wr_en && wr_be[b])
            lane_mem[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
      end

      assign rd_data[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
   end

endmodule

// File: rtl/zbt_flowthru_sram.sv
module zbt_flowthru_sram #(
   parameter int ADDR_W    = 10,
   parameter int BYTE_W    = 9,
   parameter int NUM_BYTES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clk_en_n,
   input  logic                        load_n,
   input  logic                        rd_wr_n,
   input  logic                        sel1_n,
   input  logic                        sel2,
   input  logic                        sel3_n,
   input  logic [NUM_BYTES-1:0]        byte_we_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        burst_ilv,
   input  logic                        out_en_n,
   input  logic [NUM_BYTES*BYTE_W-1:0] wdata,
   output logic [NUM_BYTES*BYTE_W-1:0] rdata,
   output logic                        rdata_vld
);
   localparam int DATA_W = NUM_BYTES * BYTE_W;

   if (ADDR_W < zbt_pkg::BURST_W || ADDR_W > 20) begin : g_bad_addr_w
      $error("ADDR_W must lie between the burst width and 20");
   end
   if (BYTE_W < 1 || NUM_BYTES < 1) begin : g_bad_word
      $error("BYTE_W and NUM_BYTES must be at least 1");
   end

   logic [ADDR_W-1:0]    cur_addr;
   logic                 rd_cyc;
   logic                 wr_cyc;
   logic                 buf_v;
   logic [ADDR_W-1:0]    buf_a;
   logic [NUM_BYTES-1:0] buf_be;
   logic [DATA_W-1:0]    buf_d;
   logic [DATA_W-1:0]    arr_d;
   logic [DATA_W-1:0]    merged;
   logic                 hit;

   zbt_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
      .rd_wr_n(rd_wr_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .addr(addr), .burst_ilv(burst_ilv), .cur_addr(cur_addr),
      .rd_cyc(rd_cyc), .wr_cyc(wr_cyc)
   );

   zbt_wr_buffer #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .wr_cyc(wr_cyc),
      .cur_addr(cur_addr), .byte_we_n(byte_we_n), .wdata(wdata),
      .buf_v(buf_v), .buf_a(buf_a), .buf_be(buf_be), .buf_d(buf_d)
   );

   zbt_mem_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_mem (
      .clk(clk), .clk_en_n(clk_en_n), .wr_en(buf_v), .wr_addr(buf_a),
      .wr_be(buf_be), .wr_data(buf_d), .rd_addr(cur_addr), .rd_data(arr_d)
   );

   // Coherent read: bytes still sitting in the write buffer win over the array.
   assign hit = buf_v && (buf_a == cur_addr);

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_merge
      assign merged[b*BYTE_W +: BYTE_W] = (hit && buf_be[b]) ? buf_d[b*BYTE_W +: BYTE_W]
                                                              : arr_d[b*BYTE_W +: BYTE_W];
   end

   assign rdata_vld = rd_cyc & ~out_en_n;
   assign rdata     = rdata_vld ? merged : '0;

   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> (!rdata_vld && rdata == '0)); // R8
   AST_DESEL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n && sel1_n) |=> !rdata_vld); // R2
   AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n && !rd_wr_n) |=> !rdata_vld); // R1

endmodule

// File: tb/zbt_flowthru_sram_tb_top.sv
module zbt_flowthru_sram_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int BW = 9;
   localparam int NB = 2;
   localparam int DW = NB * BW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_en_n = 1'b0, load_n = 1'b1, rd_wr_n = 1'b1;
   logic sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
   logic [NB-1:0] byte_we_n = '0;
   logic [AW-1:0] addr = '0;
   logic burst_ilv = 1'b0, out_en_n = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic rdata_vld;

   always #(CLK_PERIOD/2) clk = ~clk;

   zbt_flowthru_sram #(.ADDR_W(AW), .BYTE_W(BW), .NUM_BYTES(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
      .rd_wr_n(rd_wr_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .byte_we_n(byte_we_n), .addr(addr), .burst_ilv(burst_ilv),
      .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
   );

   // Reference model built from the requirements.
   logic [DW-1:0] ref_mem [1 << AW];
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;
   logic          m_act = 1'b0, m_wr = 1'b0;
   logic [NB-1:0] m_be = '0;

   logic [DW-1:0] q_data [$];
   logic          q_vld  [$];
   string         q_tag  [$];

   int  n_cmp = 0, n_bad = 0;
   bit  done = 1'b0;

   function automatic logic [AW-1:0] m_cur();
      logic [1:0] lsb;
      lsb = burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      return {m_base[AW-1:2], lsb};
   endfunction

   task automatic step(input string tag, input bit cke, input bit ld, input bit rd,
                       input logic [2:0] ce3, input logic [NB-1:0] bwn,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd);
      logic ev;
      @(negedge clk);
      clk_en_n = ~cke; load_n = ~ld; rd_wr_n = rd;
      {sel1_n, sel2, sel3_n} = ce3;
      byte_we_n = bwn; addr = a; wdata = wd;
      if (cke) begin
         if (m_act && m_wr) begin
            for (int b = 0; b < NB; b++)
               if (m_be[b]) ref_mem[m_cur()][b*BW +: BW] = wd[b*BW +: BW];
         end
         m_be = ~bwn;
         if (ld) begin
            m_base = a; m_cnt = 2'd0; m_wr = ~rd; m_act = (ce3 == 3'b010);
         end else begin
            m_cnt = m_cnt + 2'd1;
         end
      end
      ev = m_act && !m_wr && !out_en_n;
      q_vld.push_back(ev);
      q_data.push_back(ev ? ref_mem[m_cur()] : '0);
      q_tag.push_back(tag);
   endtask

   task automatic ldr(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] wd);
      step(tag, 1, 1, 1, 3'b010, 2'b00, a, wd);
   endtask
   task automatic ldw(input string tag, input logic [AW-1:0] a, input logic [NB-1:0] bwn,
                      input logic [DW-1:0] wd);
      step(tag, 1, 1, 0, 3'b010, bwn, a, wd);
   endtask
   task automatic adv(input string tag, input logic [DW-1:0] wd);
      step(tag, 1, 0, 1, 3'b010, 2'b00, '0, wd);
   endtask
   task automatic stl(input string tag, input logic [DW-1:0] wd);
      step(tag, 0, 1, 1, 3'b010, 2'b00, '0, wd);
   endtask
   task automatic dsl(input string tag, input logic [2:0] ce3, input logic [DW-1:0] wd);
      step(tag, 1, 1, 1, ce3, 2'b00, '0, wd);
   endtask

   // Monitor: compares one expected item per edge, a quarter period later.
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (q_vld.size() > 0) begin
            logic          ev;
            logic [DW-1:0] ed;
            string         tg;
            ev = q_vld.pop_front(); ed = q_data.pop_front(); tg = q_tag.pop_front();
            n_cmp++;
            if (rdata_vld !== ev || rdata !== ed) begin
               n_bad++;
               $display("FAIL %s: got vld=%0b data=%05h, expected vld=%0b data=%05h",
                        tg, rdata_vld, rdata, ev, ed);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got no finish, expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R12: nothing active after reset
      adv("R12", '0); adv("R12", '0);

      // R1 / R7 / R9: back-to-back mixed directions, late write data
      ldw("R1", 10'h010, 2'b00, '0);
      ldw("R9", 10'h011, 2'b00, 18'h1A5A5);
      ldr("R1", 10'h010, 18'h0C3C3);
      ldw("R1", 10'h012, 2'b00, 18'h3FFFF);
      ldr("R7", 10'h011, 18'h24924);
      ldr("R7", 10'h012, '0);
      ldr("R9", 10'h010, '0);

      // R10 / R6: read of buffered address, partial byte merge
      ldw("R10", 10'h005, 2'b00, '0);
      ldr("R10", 10'h005, 18'h15555);
      ldw("R6", 10'h006, 2'b00, '0);
      ldw("R6", 10'h006, 2'b10, 18'h2AAAA);
      ldr("R10", 10'h006, 18'h00155);
      ldw("R6", 10'h006, 2'b01, '0);
      ldr("R6", 10'h006, 18'h3FE00);
      ldr("R6", 10'h006, '0);

      // R5: linear write burst, then reads in both orders with wrap
      burst_ilv = 1'b0;
      ldw("R5", 10'h020, 2'b00, '0);
      adv("R5", 18'h10001);
      adv("R5", 18'h10002);
      adv("R5", 18'h10003);
      ldr("R5", 10'h022, 18'h10004);
      adv("R5", '0); adv("R5", '0); adv("R5", '0);
      @(negedge clk) burst_ilv = 1'b1;
      ldr("R5", 10'h021, '0);
      adv("R5", '0); adv("R5", '0); adv("R5", '0);
      ldr("R5", 10'h023, '0);
      adv("R5", '0); adv("R5", '0); adv("R5", '0);
      @(negedge clk) burst_ilv = 1'b0;

      // R3: stalls inside a read burst and a write burst
      ldr("R3", 10'h021, '0);
      adv("R3", '0);
      stl("R3", 18'h3DEAD);
      stl("R3", 18'h3BEEF);
      adv("R3", '0); adv("R3", '0);
      ldw("R3", 10'h030, 2'b00, '0);
      stl("R3", 18'h3FFFF);
      adv("R3", 18'h20030);
      stl("R3", 18'h3FFFF);
      adv("R3", 18'h20031);
      ldr("R3", 10'h030, 18'h20032);
      adv("R3", '0); adv("R3", '0);

      // R2 / R4: each select pin alone deselects; advance stays deselected
      ldr("R2", 10'h010, '0);
      dsl("R2", 3'b110, '0);
      ldr("R2", 10'h010, '0);
      dsl("R2", 3'b000, '0);
      adv("R4", '0);
      ldr("R2", 10'h010, '0);
      dsl("R2", 3'b011, '0);

      // R11: deselect right after a write keeps the write
      ldw("R11", 10'h040, 2'b00, '0);
      dsl("R11", 3'b110, 18'h17777);
      ldr("R11", 10'h040, '0);

      // R4: advance after a write load keeps writing
      ldw("R4", 10'h050, 2'b00, '0);
      adv("R4", 18'h05050);
      ldr("R4", 10'h051, 18'h05151);
      ldr("R4", 10'h050, '0);

      // R8: output enable gates at once, even during a stall
      ldr("R8", 10'h011, '0);
      @(negedge clk) out_en_n = 1'b1;
      stl("R8", '0);
      @(negedge clk) out_en_n = 1'b0;
      stl("R8", '0);
      adv("R8", '0);

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule